// File: doc/BRIEF.md
# Serial Receive Channel with Error Routing

This block receives asynchronous serial frames on a single input line and delivers each word on a parallel output. A single-cycle completion pulse or error pulse announces every finished frame. It runs on one operation clock. A 7-bit period field N sets the bit time to 2·(N+1) clocks, and every bit is sampled at its midpoint. A small set of mode fields selects the following:

- word length (7, 8 or 9 bits)
- bit order
- parity handling
- line inversion
- error-interrupt routing
- an optional two-sample glitch filter on the input

Framing, parity and overrun conditions are recorded in sticky flags. Software clears them by writing ones to a clear-trigger address. A plain write strobe with a 2-bit address loads the registers. A read strobe acknowledges the current word. If a new frame finishes before that acknowledgement, an overrun is reported.

Top module: `serial_rx_channel`

## Requirements
- R1: After reset the word output is 0, all three flags are 0, both pulses are low, the mode is 8-bit LSB-first without parity, and the period field is 103, which gives a 208-clock bit time.
- R2: A write to address 1 loads bits [6:0] as N. The bit time is then 2·(N+1) clocks, and each bit is sampled N+1 clocks after the detected start edge plus whole bit times.
- R3: Mode bits [1:0] select the word length: 01 gives 9 bits, 10 gives 7 bits and 11 gives 8 bits. The received word is right-aligned at bit 0 and its unused upper bits read 0.
- R4: Mode bit 2 set to 1 receives LSB first. Set to 0, it receives MSB first.
- R5: Mode bits [4:3] control parity. 00 means the frame has no parity bit. 01 means a parity bit is present but not judged. 10 checks even parity and 11 checks odd parity. A mismatch sets the parity flag.
- R6: With mode bit 5 at 1, the line is inverted before start detection and data capture, so the idle level becomes low and a start bit is a rising edge.
- R7: If the first stop bit is sampled at the non-idle level, the frame flag is set. Only the first stop bit is examined.
- R8: If a frame completes while the previous word has not been acknowledged with the read strobe, the overrun flag is set and the new word replaces the old one.
- R9: Each frame ends with exactly one single-cycle pulse. With mode bit 6 at 1 and any error in the frame, the pulse appears on the error output instead of the completion output. With mode bit 6 at 0, only the completion output pulses.
- R10: The flags are sticky. A write to address 2 clears the frame flag with bit 2, the parity flag with bit 1 and the overrun flag with bit 0. Zero bits have no effect, and a flag set in the same cycle as its clear stays set.
- R11: If the start level is no longer present at the start bit's midpoint, the receiver returns to idle without producing a pulse or changing the word.
- R12: Mode bit 7 enables an input filter. The filter changes its output only after two consecutive equal samples, so single-cycle glitches are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial input line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode, 1 period, 2 flag clear |
| wr_data | input | 8 | Write data |
| rd_strobe | input | 1 | Acknowledges the current received word |
| rx_word | output | 9 | Last received word, right-aligned |
| rx_done | output | 1 | Completion pulse |
| rx_err | output | 1 | Error pulse (routing enabled and frame in error) |
| flag_frame | output | 1 | Sticky framing error flag |
| flag_parity | output | 1 | Sticky parity error flag |
| flag_overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions check the following on every clock:

- the two pulses are mutually exclusive;
- an error pulse only occurs while routing is selected;
- flags stay set until a clear hits them;
- a clear takes effect unless a frame ends in the same cycle;
- a flag rises only together with a frame-end pulse, after which a word is pending.

Word assembly, by contrast, can only be shown by the bench's frames, sent with a range of lengths, orders, parity modes, inversion, period values and glitch patterns. The same holds for midpoint sampling, the parity-bit skip, false-start rejection and filter rejection.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int unsigned REG_W = 8;

    localparam logic [1:0] ADDR_MODE   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_CLEAR  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // Mode register layout, bit 7 down to bit 0
    typedef struct packed {
        logic       filt_en;    // [7]
        logic       err_route;  // [6]
        logic       invert;     // [5]
        logic [1:0] par;        // [4:3]
        logic       lsb_first;  // [2]
        logic [1:0] len;        // [1:0]
    } rx_mode_t;

    localparam rx_mode_t MODE_RESET = '{
        filt_en:   1'b0,
        err_route: 1'b0,
        invert:    1'b0,
        par:       2'b00,
        lsb_first: 1'b1,
        len:       2'b11
    };

    // Number of data bits for a length code; the prohibited code acts as 8
    function automatic logic [3:0] word_bits(input logic [1:0] code);
        case (code)
            2'b01:   return 4'd9;
            2'b10:   return 4'd7;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/urx_line_filter.sv
module urx_line_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_raw,
    input  logic filt_en,
    output logic line_o
);

    typedef struct packed {
        logic samp;
        logic line;
    } filt_st_t;

    filt_st_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.samp = rxd_raw;
        if (!filt_en) begin
            f_d.line = rxd_raw;
        end else if (rxd_raw == f_q.samp) begin
            // two equal samples in a row: accept the new level
            f_d.line = rxd_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{samp: 1'b1, line: 1'b1};
        end else begin
            f_q <= f_d;
        end
    end

    assign line_o = f_q.line;

endmodule

// File: rtl/urx_bit_timer.sv
module urx_bit_timer #(
    parameter int unsigned PER_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_n,
    input  logic             load_half,
    input  logic             run,
    output logic             tick
);

    localparam int unsigned     CNT_W   = PER_W + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_half) begin
            // N+1 clocks until the start-bit midpoint
            cnt_d = {1'b0, period_n};
        end else if (run) begin
            if (cnt_q == '0) begin
                // full bit time of 2*(N+1) clocks
                cnt_d = {period_n, 1'b1};
            end else begin
                cnt_d = cnt_q - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && !load_half && (cnt_q == '0);

endmodule

// File: rtl/urx_frame_engine.sv
module urx_frame_engine
    import urx_pkg::*;
#(
    parameter int unsigned WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic [1:0]        len,
    input  logic              lsb_first,
    input  logic [1:0]        par,
    input  logic              tick,
    output logic              load_half,
    output logic              run,
    output logic              fin,
    output logic              fe_o,
    output logic              pe_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int unsigned      IDX_W   = $clog2(WORD_W + 1);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    typedef struct packed {
        rx_state_e         state;
        logic              prev;
        logic [IDX_W-1:0]  idx;
        logic              acc;
        logic [WORD_W-1:0] shf;
    } eng_st_t;

    eng_st_t e_d, e_q;

    logic [IDX_W-1:0] nbits;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] pos;

    always_comb begin
        nbits    = IDX_W'(word_bits(len));
        last_idx = nbits - IDX_ONE;
        pos      = lsb_first ? e_q.idx : (last_idx - e_q.idx);

        e_d       = e_q;
        e_d.prev  = line;
        load_half = 1'b0;
        fin       = 1'b0;
        fe_o      = 1'b0;
        pe_o      = 1'b0;

        case (e_q.state)
            ST_IDLE: begin
                if (e_q.prev && !line) begin
                    e_d.state = ST_START;
                    load_half = 1'b1;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (!line) begin
                        e_d.state = ST_DATA;
                        e_d.idx   = '0;
                        e_d.acc   = 1'b0;
                        e_d.shf   = '0;
                    end else begin
                        // start level gone at midpoint: false start
                        e_d.state = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    e_d.shf[pos] = line;
                    e_d.acc      = e_q.acc ^ line;
                    if (e_q.idx == last_idx) begin
                        e_d.state = (par != 2'b00) ? ST_PAR : ST_STOP;
                    end else begin
                        e_d.idx = e_q.idx + IDX_ONE;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    e_d.acc   = e_q.acc ^ line;
                    e_d.state = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tick) begin
                    fin       = 1'b1;
                    fe_o      = !line;
                    // even check: ones must total even; odd check: odd
                    pe_o      = par[1] && (e_q.acc ^ par[0]);
                    e_d.state = ST_IDLE;
                end
            end
            default: begin
                e_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{state: ST_IDLE, prev: 1'b1, idx: '0, acc: 1'b0, shf: '0};
        end else begin
            e_q <= e_d;
        end
    end

    assign run    = (e_q.state != ST_IDLE);
    assign word_o = e_q.shf;

endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
    import urx_pkg::*;
#(
    parameter int unsigned PER_W   = 7,
    parameter int unsigned WORD_W  = 9,
    parameter int unsigned PER_RST = 103
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_done,
    output logic              rx_err,
    output logic              flag_frame,
    output logic              flag_parity,
    output logic              flag_overrun
);

    typedef struct packed {
        rx_mode_t          mode;
        logic [PER_W-1:0]  per;
        logic              fe;
        logic              pe;
        logic              ov;
        logic              pend;
        logic              done;
        logic              err;
        logic [WORD_W-1:0] word;
    } top_st_t;

    top_st_t r_d, r_q;

    logic              filt_line;
    logic              eff_line;
    logic              tick;
    logic              load_half;
    logic              run;
    logic              fin;
    logic              eng_fe;
    logic              eng_pe;
    logic [WORD_W-1:0] eng_word;
    logic [2:0]        clr_hit;
    logic              ov_now;
    logic              any_err;
    logic              route_sel;
    logic              word_pend;

    urx_line_filter u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd_raw (rxd),
        .filt_en (r_q.mode.filt_en),
        .line_o  (filt_line)
    );

    assign eff_line = filt_line ^ r_q.mode.invert;

    urx_bit_timer #(.PER_W(PER_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_n  (r_q.per),
        .load_half (load_half),
        .run       (run),
        .tick      (tick)
    );

    urx_frame_engine #(.WORD_W(WORD_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (eff_line),
        .len       (r_q.mode.len),
        .lsb_first (r_q.mode.lsb_first),
        .par       (r_q.mode.par),
        .tick      (tick),
        .load_half (load_half),
        .run       (run),
        .fin       (fin),
        .fe_o      (eng_fe),
        .pe_o      (eng_pe),
        .word_o    (eng_word)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;

        clr_hit = (wr_en && wr_addr == ADDR_CLEAR) ? wr_data[2:0] : 3'b000;
        ov_now  = r_q.pend && !rd_strobe;
        any_err = eng_fe || eng_pe || ov_now;

        if (wr_en && wr_addr == ADDR_MODE) begin
            r_d.mode = rx_mode_t'(wr_data);
        end
        if (wr_en && wr_addr == ADDR_PERIOD) begin
            r_d.per = wr_data[PER_W-1:0];
        end

        r_d.fe = r_q.fe && !clr_hit[2];
        r_d.pe = r_q.pe && !clr_hit[1];
        r_d.ov = r_q.ov && !clr_hit[0];

        if (rd_strobe) begin
            r_d.pend = 1'b0;
        end

        if (fin) begin
            r_d.word = eng_word;
            r_d.pend = 1'b1;
            r_d.fe   = r_d.fe || eng_fe;
            r_d.pe   = r_d.pe || eng_pe;
            r_d.ov   = r_d.ov || ov_now;
            r_d.err  = r_q.mode.err_route && any_err;
            r_d.done = !(r_q.mode.err_route && any_err);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{mode: MODE_RESET, per: PER_W'(PER_RST), fe: 1'b0, pe: 1'b0,
                     ov: 1'b0, pend: 1'b0, done: 1'b0, err: 1'b0, word: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign route_sel    = r_q.mode.err_route;
    assign word_pend    = r_q.pend;
    assign rx_word      = r_q.word;
    assign rx_done      = r_q.done;
    assign rx_err       = r_q.err;
    assign flag_frame   = r_q.fe;
    assign flag_parity  = r_q.pe;
    assign flag_overrun = r_q.ov;

endmodule

// File: rtl/urx_checker.sv
module urx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] clr_hit,
    input logic       route_sel,
    input logic       word_pend,
    input logic       rx_done,
    input logic       rx_err,
    input logic       flag_frame,
    input logic       flag_parity,
    input logic       flag_overrun
);

    p_pulse_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_done && rx_err));

    p_err_needs_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> $past(route_sel));

    p_frame_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_frame && !clr_hit[2]) |=> flag_frame);

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_overrun && !clr_hit[0]) |=> flag_overrun);

    p_frame_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit[2] |=> (!flag_frame || rx_done || rx_err));

    p_parity_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit[1] |=> (!flag_parity || rx_done || rx_err));

    p_flag_rise_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_frame) || $rose(flag_parity) || $rose(flag_overrun))
            |-> (rx_done || rx_err));

    p_word_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done || rx_err) |-> word_pend);

endmodule

bind serial_rx_channel urx_checker u_urx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_hit      (clr_hit),
    .route_sel    (route_sel),
    .word_pend    (word_pend),
    .rx_done      (rx_done),
    .rx_err       (rx_err),
    .flag_frame   (flag_frame),
    .flag_parity  (flag_parity),
    .flag_overrun (flag_overrun)
);

// File: tb/serial_rx_channel_bench.sv
`timescale 1ns/1ps
module serial_rx_channel_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_word;
    logic       rx_done, rx_err, flag_frame, flag_parity, flag_overrun;

    int n_cmp = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    bit summary_done = 1'b0;

    always #4 clk = ~clk;

    serial_rx_channel u_serial_rx_channel (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_strobe(rd_strobe), .rx_word(rx_word),
        .rx_done(rx_done), .rx_err(rx_err), .flag_frame(flag_frame),
        .flag_parity(flag_parity), .flag_overrun(flag_overrun)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_done) done_cnt++;
            if (rx_err)  err_cnt++;
        end
    end

    typedef struct packed {
        logic [7:0] mode;
        logic [8:0] word;
        logic       bad_par;
        logic       bad_stop;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h07, 9'h05A, 1'b0, 1'b0},   // 8b LSB, no parity
        '{8'h03, 9'h05A, 1'b0, 1'b0},   // 8b MSB
        '{8'h16, 9'h0E5, 1'b0, 1'b0},   // 7b LSB even, upper bit dropped
        '{8'h19, 9'h1A5, 1'b0, 1'b0},   // 9b MSB odd
        '{8'h17, 9'h03C, 1'b1, 1'b0},   // even, bad parity, no routing
        '{8'h57, 9'h03C, 1'b1, 1'b0},   // even, bad parity, routed
        '{8'h47, 9'h081, 1'b0, 1'b1},   // bad stop, routed
        '{8'h0F, 9'h0C3, 1'b1, 1'b0},   // parity bit present, not judged
        '{8'h37, 9'h096, 1'b0, 1'b0},   // inverted line, even
        '{8'h55, 9'h1FF, 1'b0, 1'b0},   // 9b LSB even, routed, clean
        '{8'h87, 9'h0A5, 1'b0, 1'b0},   // filter on, clean line
        '{8'h1F, 9'h0F0, 1'b1, 1'b0}    // odd, bad parity
    };

    function automatic int nbits_of(input logic [1:0] code);
        case (code)
            2'b01:   return 9;
            2'b10:   return 7;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic print_summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // mode write and idle level change land on the same clock edge
    task automatic set_mode(input logic [7:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = m;
        rxd = ~m[5];
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic ack_word();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    // one bit: p cycles, optional single-cycle inversions at offsets 6, 8, 10
    task automatic drive_bit(input logic lvl, input int p, input bit glitch);
        for (int c = 0; c < p; c++) begin
            @(negedge clk);
            rxd = lvl ^ (glitch && (c == 6 || c == 8 || c == 10));
        end
    endtask

    task automatic send_frame(input logic [8:0] w, input logic [7:0] m, input int p,
                              input bit bad_par, input bit bad_stop, input bit glitch);
        int   nb;
        logic inv;
        logic x;
        logic pb;
        nb  = nbits_of(m[1:0]);
        inv = m[5];
        x   = 1'b0;
        drive_bit(1'b0 ^ inv, p, glitch);
        for (int i = 0; i < nb; i++) begin
            logic b;
            b = m[2] ? w[i] : w[nb-1-i];
            x = x ^ b;
            drive_bit(b ^ inv, p, glitch);
        end
        if (m[4:3] != 2'b00) begin
            if (m[4]) pb = (m[3] ? ~x : x) ^ bad_par;
            else      pb = bad_par;
            drive_bit(pb ^ inv, p, glitch);
        end
        drive_bit((~bad_stop) ^ inv, p, glitch);
        drive_bit(1'b1 ^ inv, p, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        print_summary();
        $finish;
    end

    initial begin
        int d0, e0;
        logic [8:0] mask;
        logic [8:0] expw;
        logic       exp_pe, exp_fe, anyerr;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1", "word", 32'(rx_word), 32'h0);
        chk("R1", "flags", 32'({flag_frame, flag_parity, flag_overrun}), 32'h0);
        chk("R1", "pulses", 32'({rx_done, rx_err}), 32'h0);

        // R1 R2 default mode and 208-clock bit time
        d0 = done_cnt;
        send_frame(9'h033, 8'h07, 208, 1'b0, 1'b0, 1'b0);
        chk("R1", "default word", 32'(rx_word), 32'h033);
        chk("R2", "default done", 32'(done_cnt - d0), 32'd1);
        ack_word();

        reg_write(2'd1, 8'd7);   // 16-clock bits

        // table of frames
        for (int i = 0; i < NV; i++) begin
            set_mode(VECS[i].mode);
            d0 = done_cnt; e0 = err_cnt;
            send_frame(VECS[i].word, VECS[i].mode, 16, VECS[i].bad_par, VECS[i].bad_stop, 1'b0);
            mask   = 9'((1 << nbits_of(VECS[i].mode[1:0])) - 1);
            expw   = VECS[i].word & mask;
            exp_pe = VECS[i].mode[4] && VECS[i].bad_par;
            exp_fe = VECS[i].bad_stop;
            anyerr = exp_pe || exp_fe;
            chk("R3 R4 R6", $sformatf("vec %0d word", i), 32'(rx_word), 32'(expw));
            chk("R5", $sformatf("vec %0d parity flag", i), 32'(flag_parity), 32'(exp_pe));
            chk("R7", $sformatf("vec %0d frame flag", i), 32'(flag_frame), 32'(exp_fe));
            chk("R9", $sformatf("vec %0d done pulses", i), 32'(done_cnt - d0),
                32'((VECS[i].mode[6] && anyerr) ? 0 : 1));
            chk("R9", $sformatf("vec %0d err pulses", i), 32'(err_cnt - e0),
                32'((VECS[i].mode[6] && anyerr) ? 1 : 0));
            reg_write(2'd2, 8'h07);
            ack_word();
        end
        set_mode(8'h07);

        // R2 shorter bit time, N=3
        reg_write(2'd1, 8'd3);
        d0 = done_cnt;
        send_frame(9'h0A7, 8'h07, 8, 1'b0, 1'b0, 1'b0);
        chk("R2", "N=3 word", 32'(rx_word), 32'h0A7);
        chk("R2", "N=3 done", 32'(done_cnt - d0), 32'd1);
        ack_word();
        reg_write(2'd1, 8'd7);

        // R8 overrun
        d0 = done_cnt; e0 = err_cnt;
        send_frame(9'h011, 8'h07, 16, 1'b0, 1'b0, 1'b0);
        send_frame(9'h022, 8'h07, 16, 1'b0, 1'b0, 1'b0);
        chk("R8", "overrun flag", 32'(flag_overrun), 32'h1);
        chk("R8", "newest word", 32'(rx_word), 32'h022);
        chk("R8", "done pulses", 32'(done_cnt - d0), 32'd2);
        set_mode(8'h47);
        d0 = done_cnt; e0 = err_cnt;
        send_frame(9'h033, 8'h47, 16, 1'b0, 1'b0, 1'b0);
        chk("R9", "overrun routed err", 32'(err_cnt - e0), 32'd1);
        chk("R9", "overrun routed done", 32'(done_cnt - d0), 32'd0);

        // R10 clear trigger
        reg_write(2'd2, 8'h00);
        chk("R10", "zero clear keeps overrun", 32'(flag_overrun), 32'h1);
        reg_write(2'd2, 8'h04);
        chk("R10", "frame clear keeps overrun", 32'(flag_overrun), 32'h1);
        reg_write(2'd2, 8'h01);
        chk("R10", "overrun cleared", 32'(flag_overrun), 32'h0);
        ack_word();
        set_mode(8'h07);

        // R11 false start: one-cycle low pulse
        d0 = done_cnt; e0 = err_cnt;
        @(negedge clk); rxd = 1'b0;
        @(negedge clk); rxd = 1'b1;
        repeat (48) @(negedge clk);
        chk("R11", "no pulse", 32'((done_cnt - d0) + (err_cnt - e0)), 32'd0);
        chk("R11", "word kept", 32'(rx_word), 32'h033);

        // R12 filter rejects single-cycle glitches
        set_mode(8'h87);
        d0 = done_cnt;
        send_frame(9'h05A, 8'h87, 16, 1'b0, 1'b0, 1'b1);
        chk("R12", "filtered word", 32'(rx_word), 32'h05A);
        chk("R12", "filtered done", 32'(done_cnt - d0), 32'd1);
        chk("R12", "filtered flags", 32'({flag_frame, flag_parity, flag_overrun}), 32'h0);
        ack_word();

        // R12 same glitches without the filter corrupt or drop the frame
        set_mode(8'h07);
        d0 = done_cnt;
        send_frame(9'h05A, 8'h07, 16, 1'b0, 1'b0, 1'b1);
        repeat (32) @(negedge clk);
        chk("R12", "unfiltered not clean",
            32'((done_cnt == d0) || (rx_word != 9'h05A)), 32'h1);

        print_summary();
        $finish;
    end

endmodule